// File: doc/BRIEF.md
# LPC Host Cycle Splitter

This block is the host side of a Low Pin Count bus for memory and I/O accesses. It takes one host request of 1, 2 or 4 bytes. The request carries a base address, a byte count, a direction and a memory-or-I/O select, plus write data for a write. The block turns the request into a run of single-byte LPC frames on a 4-bit LAD bus, framed by an active-low frame strobe.

Each frame goes through a fixed sequence:
- start nibble;
- cycle code;
- address nibbles;
- write data, for a write;
- turnaround;
- sync;
- read data, for a read;
- a final turnaround.

A frame that no peripheral claims within a bounded number of clocks is aborted on the bus. The block then substitutes all ones for that read byte and still carries out the remaining bytes of the request. The read bytes are merged into one host-width result. Completion is reported once per request, together with an error flag.

Top module: `lpc_split_host`

## Requirements
- R1: After reset `lframe_no` is 1, `lad_oe_o` is 0, `req_ready_o` is 1 and `done_o` is 0.
- R2: `req_size_i` selects the byte count: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes. A request becomes exactly that many single-byte frames, one after another. Each frame begins with start nibble 4'b0000 driven while `lframe_no` is 0.
- R3: Sub-cycles run in ascending address order. Sub-cycle k uses address base+k and write data byte `req_wdata_i[8k+7:8k]`.
- R4: `lframe_no` is 0 for exactly the one start clock. Next the block drives the cycle code {0, is_mem, is_write, 0}. Then it drives the address, most significant nibble first: 8 nibbles for memory, or the low 16 bits as 4 nibbles for I/O.
- R5: A write drives its data byte low nibble first. After the address (and data, for a write) comes a two-clock turnaround: 4'b1111 driven for one clock, then LAD released. LAD stays released through sync, read data and the final two-clock turnaround.
- R6: Sync 4'b0000 means ready. Sync 4'b0101 or 4'b0110 means wait and restarts the timeout, so any number of waits is accepted.
- R7: After SYNC_TMO consecutive sync clocks that carry no ready and no wait, the block aborts the frame. It drives `lframe_no`=0 with LAD=4'b1111 for ABORT_CLKS clocks.
- R8: Read data is taken low nibble first into byte k of `rdata_o`. An aborted read byte reads as 8'hFF. Bytes beyond the request size, and all bytes of a write, read as 0.
- R9: After an aborted frame, the remaining sub-cycles of the request are still performed. `done_o` pulses once, one clock after the last frame ends. `err_o` is 1 if any frame of the request was aborted.
- R10: A request is accepted only while `req_ready_o` is 1. `req_valid_i` is ignored while a request is in flight.
- R11: The only start nibbles ever driven with `lframe_no` low are 4'b0000 and 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request strobe |
| req_ready_o | output | 1 | Idle, request can be accepted |
| req_addr_i | input | 32 | Base byte address |
| req_size_i | input | 2 | Byte count code (0:1, 1:2, 2/3:4) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata_i | input | 32 | Write data, byte k to sub-cycle k |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Merged read result, valid from `done_o` |
| err_o | output | 1 | Some byte of the request was unclaimed |
| lframe_no | output | 1 | Active-low frame strobe |
| lad_o | output | 4 | LAD drive value |
| lad_oe_o | output | 1 | LAD output enable |
| lad_i | input | 4 | LAD sampled value |

## Verification
The hardest case is a partly claimed wide read. It needs an abort in the middle of a 4-byte request, followed by the continuation of the remaining bytes. It must end in a single completion that carries both the real bytes and the substituted 8'hFF. The bench peripheral takes a per-byte claim mask and withholds sync on only one chosen sub-cycle. A second case answers with more consecutive wait syncs than the timeout count, which shows that waits never trigger an abort. A request presented mid-transfer checks that the in-flight address sequence is undisturbed.

// File: rtl/lpc_split_pkg.sv
package lpc_split_pkg;

  typedef enum logic [3:0] {
    FR_IDLE, FR_START, FR_CTDIR, FR_ADDR, FR_WDATA,
    FR_TAR, FR_SYNC, FR_RDATA, FR_TAR2, FR_ABORT
  } frame_state_e;

  localparam logic [3:0] NIB_START  = 4'b0000;
  localparam logic [3:0] NIB_ABORT  = 4'b1111;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;

  function automatic logic [3:0] cyc_code(input logic is_mem, input logic is_wr);
    return {1'b0, is_mem, is_wr, 1'b0};
  endfunction

endpackage

// File: rtl/lpc_byte_frame.sv
module lpc_byte_frame
  import lpc_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SYNC_TMO   = 8,
  parameter int ABORT_CLKS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          io_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          byte_done_o,
  output logic          unclaimed_o,
  output logic [7:0]    rbyte_o,
  output logic          lframe_no,
  output logic [3:0]    lad_o,
  output logic          lad_oe_o,
  input  logic [3:0]    lad_i
);

  localparam int MEM_NIBS = AW / 4;
  localparam int IO_NIBS  = 4;
  localparam int MAXC     = (SYNC_TMO > ABORT_CLKS) ?
                            ((SYNC_TMO > MEM_NIBS) ? SYNC_TMO : MEM_NIBS) :
                            ((ABORT_CLKS > MEM_NIBS) ? ABORT_CLKS : MEM_NIBS);
  localparam int CW       = $clog2(MAXC + 1);

  frame_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdata_q, rbyte_q;
  logic          io_q, write_q;
  logic [CW-1:0] addr_last;
  int            nib_sel;
  logic          sync_wait, sync_bad, tmo_hit;

  assign addr_last = io_q ? CW'(IO_NIBS - 1) : CW'(MEM_NIBS - 1);
  assign nib_sel   = int'(addr_last) - int'(cnt_q);
  assign sync_wait = (lad_i == SYNC_SHORT) || (lad_i == SYNC_LONG);
  assign sync_bad  = (lad_i != SYNC_READY) && !sync_wait;
  assign tmo_hit   = (state_q == FR_SYNC) && sync_bad && (cnt_q == CW'(SYNC_TMO - 1));

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    lframe_no   = 1'b1;
    lad_o       = NIB_ABORT;
    lad_oe_o    = 1'b0;
    byte_done_o = 1'b0;
    case (state_q)
      FR_IDLE: if (start_i) begin
        state_d = FR_START;
        cnt_d   = '0;
      end
      FR_START: begin
        lframe_no = 1'b0;
        lad_oe_o  = 1'b1;
        lad_o     = NIB_START;
        state_d   = FR_CTDIR;
      end
      FR_CTDIR: begin
        lad_oe_o = 1'b1;
        lad_o    = cyc_code(!io_q, write_q);
        state_d  = FR_ADDR;
        cnt_d    = '0;
      end
      FR_ADDR: begin
        lad_oe_o = 1'b1;
        lad_o    = addr_q[4*nib_sel +: 4];
        if (cnt_q == addr_last) begin
          cnt_d   = '0;
          state_d = write_q ? FR_WDATA : FR_TAR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FR_WDATA: begin
        lad_oe_o = 1'b1;
        lad_o    = cnt_q[0] ? wdata_q[7:4] : wdata_q[3:0];
        if (cnt_q[0]) begin
          cnt_d   = '0;
          state_d = FR_TAR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FR_TAR: begin
        if (cnt_q == '0) begin
          lad_oe_o = 1'b1;
          cnt_d    = cnt_q + 1'b1;
        end else begin
          cnt_d   = '0;
          state_d = FR_SYNC;
        end
      end
      FR_SYNC: begin
        if (lad_i == SYNC_READY) begin
          cnt_d   = '0;
          state_d = write_q ? FR_TAR2 : FR_RDATA;
        end else if (sync_wait) begin
          cnt_d = '0;
        end else if (tmo_hit) begin
          cnt_d   = '0;
          state_d = FR_ABORT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FR_RDATA: begin
        if (cnt_q[0]) begin
          cnt_d   = '0;
          state_d = FR_TAR2;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FR_TAR2: begin
        if (cnt_q[0]) begin
          cnt_d       = '0;
          byte_done_o = 1'b1;
          state_d     = FR_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FR_ABORT: begin
        lframe_no = 1'b0;
        lad_oe_o  = 1'b1;
        lad_o     = NIB_ABORT;
        if (cnt_q == CW'(ABORT_CLKS - 1)) begin
          cnt_d       = '0;
          byte_done_o = 1'b1;
          state_d     = FR_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rbyte_q <= '0;
      io_q    <= 1'b0;
      write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == FR_IDLE && start_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        io_q    <= io_i;
        write_q <= write_i;
        rbyte_q <= '0;
      end
      if (state_q == FR_RDATA) begin
        if (cnt_q[0]) rbyte_q[7:4] <= lad_i;
        else          rbyte_q[3:0] <= lad_i;
      end
    end
  end

  assign unclaimed_o = (state_q == FR_ABORT);
  assign rbyte_o     = unclaimed_o ? 8'hFF : rbyte_q;

  AST_START_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lframe_no && lad_oe_o) |-> (lad_o == NIB_START || lad_o == NIB_ABORT)); // R11
  AST_START_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FR_START) |=> lframe_no); // R4
  AST_TMO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_hit |=> (!lframe_no && lad_o == NIB_ABORT)); // R7
  AST_WAIT_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FR_SYNC && sync_wait) |=> (state_q == FR_SYNC)); // R6

endmodule

// File: rtl/lpc_req_seq.sv
module lpc_req_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_write_i,
  input  logic          req_io_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          go_o,
  output logic [AW-1:0] sub_addr_o,
  output logic [7:0]    sub_wdata_o,
  output logic          sub_io_o,
  output logic          sub_write_o,
  input  logic          byte_done_i,
  input  logic          unclaimed_i,
  input  logic [7:0]    rbyte_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o
);

  localparam int NB   = DW / 8;
  localparam int IDXW = (NB > 1) ? $clog2(NB) : 1;

  logic            busy_q, go_q, done_q, err_q, io_q, write_q;
  logic [IDXW-1:0] idx_q, last_q, last_d;
  logic [AW-1:0]   base_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic            accept;

  assign accept = req_valid_i && !busy_q;

  always_comb begin
    if (int'(req_size_i) >= $clog2(NB)) last_d = IDXW'(NB - 1);
    else                                last_d = IDXW'((1 << req_size_i) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      io_q    <= 1'b0;
      write_q <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      base_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        go_q    <= 1'b1;
        idx_q   <= '0;
        last_q  <= last_d;
        base_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        io_q    <= req_io_i;
        write_q <= req_write_i;
        rdata_q <= '0;
        err_q   <= 1'b0;
      end else if (busy_q && byte_done_i) begin
        if (!write_q) rdata_q[8*idx_q +: 8] <= rbyte_i;
        if (unclaimed_i) err_q <= 1'b1;
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          go_q  <= 1'b1;
        end
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign go_o        = go_q;
  assign sub_addr_o  = base_q + AW'(idx_q);
  assign sub_wdata_o = wdata_q[8*idx_q +: 8];
  assign sub_io_o    = io_q;
  assign sub_write_o = write_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign err_o       = err_q;

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && byte_done_i && idx_q != last_q) |=> (idx_q == $past(idx_q) + 1'b1)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && req_valid_i) |=> $stable(base_q)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9

endmodule

// File: rtl/lpc_split_host.sv
module lpc_split_host
  import lpc_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SYNC_TMO   = 8,
  parameter int ABORT_CLKS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_write_i,
  input  logic          req_io_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          lframe_no,
  output logic [3:0]    lad_o,
  output logic          lad_oe_o,
  input  logic [3:0]    lad_i
);

  logic          go, sub_io, sub_write, byte_done, unclaimed;
  logic [AW-1:0] sub_addr;
  logic [7:0]    sub_wdata, rbyte;

  lpc_req_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .req_write_i (req_write_i),
    .req_io_i    (req_io_i),
    .req_wdata_i (req_wdata_i),
    .go_o        (go),
    .sub_addr_o  (sub_addr),
    .sub_wdata_o (sub_wdata),
    .sub_io_o    (sub_io),
    .sub_write_o (sub_write),
    .byte_done_i (byte_done),
    .unclaimed_i (unclaimed),
    .rbyte_i     (rbyte),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .err_o       (err_o)
  );

  lpc_byte_frame #(.AW(AW), .SYNC_TMO(SYNC_TMO), .ABORT_CLKS(ABORT_CLKS)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (go),
    .io_i        (sub_io),
    .write_i     (sub_write),
    .addr_i      (sub_addr),
    .wdata_i     (sub_wdata),
    .byte_done_o (byte_done),
    .unclaimed_o (unclaimed),
    .rbyte_o     (rbyte),
    .lframe_no   (lframe_no),
    .lad_o       (lad_o),
    .lad_oe_o    (lad_oe_o),
    .lad_i       (lad_i)
  );

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o && lframe_no)); // R9

endmodule

// File: tb/lpc_split_host_bench.sv
module lpc_split_host_bench;

  localparam int SYNC_TMO   = 8;
  localparam int ABORT_CLKS = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_io_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        done_o;
  logic [31:0] rdata_o;
  logic        err_o;
  logic        lframe_no;
  logic [3:0]  lad_o;
  logic        lad_oe_o;
  logic [3:0]  lad_i = 4'hF;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int bad_start = 0;

  always #10 clk = ~clk;

  lpc_split_host #(.SYNC_TMO(SYNC_TMO), .ABORT_CLKS(ABORT_CLKS)) u_lpc_split_host (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i),
    .req_write_i(req_write_i), .req_io_i(req_io_i), .req_wdata_i(req_wdata_i),
    .done_o(done_o), .rdata_o(rdata_o), .err_o(err_o),
    .lframe_no(lframe_no), .lad_o(lad_o), .lad_oe_o(lad_oe_o), .lad_i(lad_i)
  );

  always @(negedge clk) begin
    if (done_o) done_cnt++;
    if (!lframe_no && lad_oe_o && lad_o != 4'h0 && lad_o != 4'hF) bad_start++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    chk(bad_start == 0, "R11 reserved start nibble", bad_start, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // peripheral side of one single-byte frame
  task automatic serve_byte(input logic [31:0] a, input bit io, input bit wr, input logic [7:0] wd,
                            input int nwait, input bit claim, input logic [7:0] rb);
    int n;
    n = io ? 4 : 8;
    @(negedge clk);
    while (!(!lframe_no && lad_oe_o && lad_o == 4'h0)) @(negedge clk);
    @(negedge clk);
    chk(lframe_no && lad_oe_o && lad_o == {1'b0, !io, wr, 1'b0}, "R4 cycle code",
        {27'd0, lframe_no, lad_o}, {28'h1, 1'b0, !io, wr, 1'b0});
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(lad_oe_o && lad_o == a[4*(n-1-i) +: 4], "R3/R4 address nibble", lad_o, a[4*(n-1-i) +: 4]);
    end
    if (wr) begin
      @(negedge clk);
      chk(lad_oe_o && lad_o == wd[3:0], "R5 write low nibble", lad_o, wd[3:0]);
      @(negedge clk);
      chk(lad_oe_o && lad_o == wd[7:4], "R5 write high nibble", lad_o, wd[7:4]);
    end
    @(negedge clk);
    chk(lad_oe_o && lad_o == 4'hF, "R5 turnaround drive", {lad_oe_o, lad_o}, 5'h1F);
    @(negedge clk);
    chk(!lad_oe_o, "R5 turnaround release", lad_oe_o, 0);
    if (claim) begin
      for (int w = 0; w < nwait; w++) begin
        @(negedge clk);
        lad_i = (w % 2 == 1) ? 4'h6 : 4'h5;
        chk(lframe_no && !lad_oe_o, "R6 wait no abort", {lframe_no, lad_oe_o}, 2'b10);
      end
      @(negedge clk);
      chk(lframe_no && !lad_oe_o, "R6 sync released", {lframe_no, lad_oe_o}, 2'b10);
      lad_i = 4'h0;
      if (!wr) begin
        @(negedge clk);
        lad_i = rb[3:0];
        @(negedge clk);
        lad_i = rb[7:4];
      end
      @(negedge clk);
      lad_i = 4'hF;
      chk(!lad_oe_o, "R5 final turnaround released", lad_oe_o, 0);
      @(negedge clk);
    end else begin
      for (int k = 0; k < SYNC_TMO; k++) begin
        @(negedge clk);
        lad_i = 4'hF;
        chk(lframe_no, "R7 no early abort", lframe_no, 1);
      end
      for (int k = 0; k < ABORT_CLKS; k++) begin
        @(negedge clk);
        chk(!lframe_no && lad_oe_o && lad_o == 4'hF, "R7 abort drive",
            {lframe_no, lad_oe_o, lad_o}, 6'h1F);
      end
    end
  endtask

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input bit wr, input bit io,
                         input logic [31:0] wd, input logic [3:0] claim, input int nwait,
                         input logic [31:0] rd, input bit intrude);
    int nb, d0;
    logic [31:0] exp_rd;
    logic exp_err;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    exp_rd = '0;
    exp_err = 1'b0;
    for (int k = 0; k < nb; k++) begin
      if (!wr) exp_rd[8*k +: 8] = claim[k] ? rd[8*k +: 8] : 8'hFF;
      if (!claim[k]) exp_err = 1'b1;
    end
    d0 = done_cnt;
    @(negedge clk);
    chk(req_ready_o, "R10 ready when idle", req_ready_o, 1);
    req_addr_i = a; req_size_i = sz; req_write_i = wr; req_io_i = io; req_wdata_i = wd;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    fork
      begin
        for (int k = 0; k < nb; k++)
          serve_byte(a + k, io, wr, wd[8*k +: 8], nwait, claim[k], rd[8*k +: 8]);
      end
      begin
        while (!done_o) @(negedge clk);
        chk(rdata_o == exp_rd, "R8 merged read data", rdata_o, exp_rd);
        chk(err_o == exp_err, "R9 error flag", err_o, exp_err);
      end
      begin
        if (intrude) begin
          repeat (6) @(negedge clk);
          chk(!req_ready_o, "R10 busy not ready", req_ready_o, 0);
          req_addr_i = 32'hDEAD_0000; req_valid_i = 1'b1;
          @(negedge clk);
          req_valid_i = 1'b0;
        end
      end
    join
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 single done pulse", done_cnt - d0, 1);
    if (intrude) begin
      for (int i = 0; i < 6; i++) begin
        chk(lframe_no, "R10 ignored request started no frame", lframe_no, 1);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(lframe_no, "R1 lframe high", lframe_no, 1);
    chk(!lad_oe_o, "R1 lad released", lad_oe_o, 0);
    chk(req_ready_o, "R1 ready", req_ready_o, 1);
    chk(!done_o, "R1 done low", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // R2: one-byte I/O read with waits
  task automatic t_io_read_byte();
    run_req(32'h0000_03F8, 2'd0, 1'b0, 1'b1, '0, 4'b1111, 2, 32'h0000_005A, 1'b0);
  endtask

  // R3: four-byte memory write crossing a byte-address carry
  task automatic t_mem_write_word();
    run_req(32'h1234_56FE, 2'd2, 1'b1, 1'b0, 32'hA1B2_C3D4, 4'b1111, 0, '0, 1'b0);
  endtask

  // R6: more waits than the timeout count
  task automatic t_mem_read_long_wait();
    run_req(32'h000C_8001, 2'd1, 1'b0, 1'b0, '0, 4'b1111, SYNC_TMO + 4, 32'h0000_BEEF, 1'b0);
  endtask

  // R7 R9: byte 1 of a four-byte read is unclaimed
  task automatic t_partial_claim();
    run_req(32'h0000_0060, 2'd2, 1'b0, 1'b1, '0, 4'b1101, 1, 32'h1122_3344, 1'b0);
  endtask

  // R10: request during a transfer is ignored
  task automatic t_busy_request();
    run_req(32'h0000_4000, 2'd1, 1'b0, 1'b0, '0, 4'b1111, 3, 32'h0000_77A5, 1'b1);
  endtask

  // R2 R9: size code 3 runs four bytes, all unclaimed writes
  task automatic t_write_unclaimed();
    run_req(32'h0000_0080, 2'd3, 1'b1, 1'b1, 32'h0102_0304, 4'b0000, 0, '0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_io_read_byte();
    t_mem_write_word();
    t_mem_read_long_wait();
    t_partial_claim();
    t_busy_request();
    t_write_unclaimed();
    finish_run();
  end

endmodule